// File: doc/BRIEF.md
# UART Transmitter with Clear-to-Send Flow Control

This block sends bytes as asynchronous serial frames on a single output line. The producer writes bytes through a valid/ready port into a 16-entry queue. The engine takes bytes from the queue and frames each one with a low start bit, eight data bits sent least significant bit first, an optional even or odd parity bit and a high stop bit. The bit rate is set by an external baud tick, and every bit lasts 16 ticks.

When automatic flow control is on, the peer can pause the engine by driving the active-low clear-to-send input high. That input passes through a two-flop synchronizer. The engine checks it only where a new frame would begin. A frame already on the line always finishes, stop bit included. The line then stays high until clear-to-send goes low again, and the next queued byte follows from there. When flow control is off, clear-to-send has no effect and frames go out back to back while the queue holds data.

Top module: `uart_tx_cts`

## Requirements
- R1: After reset, `txd` is 1 and `wr_ready` is 1.
- R2: Each frame is sent in this order: a start bit of 0, then data bits 0 through 7 (least significant first), then a stop bit of 1. Bytes leave in the order they were accepted.
- R3: Every bit holds for exactly 16 baud ticks, and `txd` changes only on a cycle that has a baud tick. While the queue stays non-empty and transmission is allowed, a new frame starts exactly 16 × (frame bit count) ticks after the previous one: 10 bits without parity, 11 bits with parity.
- R4: When `parity_en` is 1, one parity bit is sent between data bit 7 and the stop bit. With `parity_odd` = 0 the data plus parity hold an even number of ones. With `parity_odd` = 1 they hold an odd number of ones.
- R5: The queue holds up to 16 bytes. `wr_ready` is 0 while it is full, and a write presented while full is not accepted.
- R6: When `flow_en` is 1 and the synchronized `cts_n` is 1 at the tick where a frame would start, no frame starts and `txd` stays 1.
- R7: If `cts_n` rises while a frame is on the line, that frame still completes with a valid stop bit.
- R8: After `cts_n` returns to 0, sending resumes with a start bit and the next queued byte, in queue order.
- R9: When `flow_en` is 0, `cts_n` has no effect.
- R10: While the queue is empty, `txd` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write request for a byte |
| wr_data | input | 8 | Byte to queue |
| wr_ready | output | 1 | Queue can accept a byte (registered) |
| baud_tick | input | 1 | One-cycle tick; 16 ticks make one bit |
| flow_en | input | 1 | Enables clear-to-send flow control |
| parity_en | input | 1 | Adds a parity bit to each frame |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cts_n | input | 1 | Clear-to-send from the peer, active low, asynchronous |
| txd | output | 1 | Serial output, idle high (registered) |

## Verification
A corrupted queue pointer or count shows up at the line within one frame. The symptom is a byte out of order, a repeated byte or a missing byte, or `wr_ready` changing at the wrong fill level. A bad bit counter or bad state register breaks the framing of the very frame it affects. It appears as a misplaced stop or parity bit, or a start-to-start spacing different from 16 ticks per bit. A flow-control fault appears at the first frame boundary after `cts_n` changes. The fault is either a start bit while the peer is not ready, or a frame cut short.

// File: rtl/uatx_pkg.sv
package uatx_pkg;
  typedef enum logic [2:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_PAR,
    TX_STOP
  } tx_state_e;
endpackage

// File: rtl/uatx_sync.sv
module uatx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= {STAGES{RST_VAL}};
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/uatx_fifo.sv
module uatx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic [CNT_W-1:0]  count,
  output logic              ready
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count_nx;

  // storage has no reset so it can map onto RAM resources
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_comb begin
    unique case ({push, pop})
      2'b10:   count_nx = count + CNT_W'(1);
      2'b01:   count_nx = count - CNT_W'(1);
      default: count_nx = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ready  <= 1'b1;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + PTR_W'(1);
      count <= count_nx;
      ready <= (count_nx != CNT_FULL);
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = (count == '0);
endmodule

// File: rtl/uatx_serializer.sv
module uatx_serializer
  import uatx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16,
  localparam int TC_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1,
  localparam int BI_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [DATA_W-1:0] head,
  input  logic              q_empty,
  input  logic              flow_en,
  input  logic              cts_n_s,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              pop,
  output logic              txd
);
  localparam logic [TC_W-1:0] TC_LAST = TC_W'(TICKS_PER_BIT - 1);
  localparam logic [BI_W-1:0] BI_LAST = BI_W'(DATA_W - 1);

  tx_state_e         state;
  logic [TC_W-1:0]   tcnt;
  logic [BI_W-1:0]   bidx;
  logic [DATA_W-1:0] shreg;
  logic              par_bit, par_use;
  logic              last_tick, may_start, at_boundary;

  assign last_tick   = (tcnt == TC_LAST);
  assign may_start   = !q_empty && (!flow_en || !cts_n_s);
  assign at_boundary = (state == TX_IDLE) || (state == TX_STOP && last_tick);
  assign pop         = tick && may_start && at_boundary;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= TX_IDLE;
      txd     <= 1'b1;
      tcnt    <= '0;
      bidx    <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
      par_use <= 1'b0;
    end else if (tick) begin
      if (pop) begin
        state   <= TX_START;
        txd     <= 1'b0;
        tcnt    <= '0;
        shreg   <= head;
        par_bit <= (^head) ^ par_odd;
        par_use <= par_en;
      end else if (state == TX_IDLE) begin
        txd  <= 1'b1;
        tcnt <= '0;
      end else if (!last_tick) begin
        tcnt <= tcnt + TC_W'(1);
      end else begin
        tcnt <= '0;
        unique case (state)
          TX_START: begin
            state <= TX_DATA;
            bidx  <= '0;
            txd   <= shreg[0];
            shreg <= shreg >> 1;
          end
          TX_DATA: begin
            if (bidx == BI_LAST) begin
              state <= par_use ? TX_PAR : TX_STOP;
              txd   <= par_use ? par_bit : 1'b1;
            end else begin
              bidx  <= bidx + BI_W'(1);
              txd   <= shreg[0];
              shreg <= shreg >> 1;
            end
          end
          TX_PAR: begin
            state <= TX_STOP;
            txd   <= 1'b1;
          end
          default: begin
            state <= TX_IDLE;
            txd   <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_tx_cts.sv
module uart_tx_cts #(
  parameter int DATA_W        = 8,
  parameter int DEPTH         = 16,
  parameter int TICKS_PER_BIT = 16,
  parameter int SYNC_STAGES   = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              baud_tick,
  input  logic              flow_en,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              cts_n,
  output logic              txd
);
  logic [DATA_W-1:0] q_head;
  logic              q_empty;
  logic [CNT_W-1:0]  q_count;
  logic              tx_pop;
  logic              cts_n_s;
  logic              q_push;

  assign q_push = wr_valid && wr_ready;

  uatx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (cts_n),
    .q   (cts_n_s)
  );

  uatx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (q_push),
    .push_data (wr_data),
    .pop       (tx_pop),
    .head      (q_head),
    .empty     (q_empty),
    .count     (q_count),
    .ready     (wr_ready)
  );

  uatx_serializer #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_ser (
    .clk     (clk),
    .rst     (rst),
    .tick    (baud_tick),
    .head    (q_head),
    .q_empty (q_empty),
    .flow_en (flow_en),
    .cts_n_s (cts_n_s),
    .par_en  (parity_en),
    .par_odd (parity_odd),
    .pop     (tx_pop),
    .txd     (txd)
  );
endmodule

// File: rtl/uatx_checker.sv
module uatx_checker #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_ready,
  input logic             baud_tick,
  input logic             flow_en,
  input logic             txd,
  input logic             pop,
  input logic             cts_n_s,
  input logic [CNT_W-1:0] q_count
);
  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> txd);

  assert_start_follows_pop_R2: assert property (@(posedge clk) disable iff (rst)
    pop |=> !txd);

  assert_line_moves_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    !baud_tick |=> $stable(txd));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    q_count <= CNT_W'(DEPTH));

  assert_full_blocks_write_R5: assert property (@(posedge clk) disable iff (rst)
    (q_count == CNT_W'(DEPTH)) |-> !wr_ready);

  assert_no_start_when_blocked_R6: assert property (@(posedge clk) disable iff (rst)
    pop |-> (!flow_en || !cts_n_s));

  assert_no_pop_when_empty_R10: assert property (@(posedge clk) disable iff (rst)
    pop |-> (q_count != '0));
endmodule

bind uart_tx_cts uatx_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_ready  (wr_ready),
  .baud_tick (baud_tick),
  .flow_en   (flow_en),
  .txd       (txd),
  .pop       (tx_pop),
  .cts_n_s   (cts_n_s),
  .q_count   (q_count)
);

// File: tb/tb_uart_tx_cts.sv
module tb_uart_tx_cts;
  localparam int CLK_PERIOD = 10;
  localparam int TPB        = 16;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ready;
  logic       baud_tick = 1'b0;
  logic       flow_en = 1'b0;
  logic       parity_en = 1'b0;
  logic       parity_odd = 1'b0;
  logic       cts_n = 1'b0;
  logic       txd;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_tx_cts dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .baud_tick(baud_tick), .flow_en(flow_en),
    .parity_en(parity_en), .parity_odd(parity_odd), .cts_n(cts_n), .txd(txd)
  );

  // baud tick generator: one tick every tick_div cycles
  int tick_div = 2;
  int tick_ph  = 0;
  always @(posedge clk) begin
    if (tick_ph + 1 >= tick_div) begin
      tick_ph   <= 0;
      baud_tick <= 1'b1;
    end else begin
      tick_ph   <= tick_ph + 1;
      baud_tick <= 1'b0;
    end
  end

  function automatic void check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endfunction

  function automatic bit exp_parity(logic [7:0] d, logic odd);
    return (^d) ^ odd;
  endfunction

  function automatic int frame_bits(logic pe);
    return pe ? 11 : 10;
  endfunction

  // expected byte order and line decoder
  logic [7:0] exp_q[$];
  bit         rx_busy = 0;
  int         rx_cnt  = 0;
  int         rx_n    = 0;
  logic [10:0] rx_bits;
  longint     gtick = 0;
  longint     last_start = 0;
  bit         gap_chk = 0;
  bit         have_prev = 0;

  task automatic finish_frame();
    logic [7:0] d;
    int nb;
    nb = frame_bits(parity_en);
    d  = rx_bits[8:1];
    check(rx_bits[0] == 1'b0, "R2 start bit", int'(rx_bits[0]), 0);
    if (parity_en)
      check(rx_bits[9] == exp_parity(d, parity_odd), "R4 parity bit",
            int'(rx_bits[9]), int'(exp_parity(d, parity_odd)));
    check(rx_bits[nb-1] == 1'b1, "R2 stop bit", int'(rx_bits[nb-1]), 1);
    if (exp_q.size() == 0) begin
      check(1'b0, "R2 unexpected frame", int'(d), -1);
    end else begin
      check(d == exp_q[0], "R2 data order", int'(d), int'(exp_q[0]));
      void'(exp_q.pop_front());
    end
    rx_n++;
    rx_busy = 0;
  endtask

  always @(negedge clk) begin
    if (rst) begin
      rx_busy = 0;
    end else begin
      if (!rx_busy) begin
        if (txd === 1'b0) begin
          rx_busy = 1;
          rx_bits = '1;
          rx_cnt  = baud_tick ? 1 : 0;
          if (gap_chk && have_prev)
            check((gtick - last_start) == longint'(TPB * frame_bits(parity_en)),
                  "R3 start spacing", int'(gtick - last_start), TPB * frame_bits(parity_en));
          last_start = gtick;
          have_prev  = 1;
        end
      end else if (baud_tick) begin
        rx_cnt++;
        if (rx_cnt % TPB == TPB/2) begin
          rx_bits[rx_cnt / TPB] = txd;
          if (rx_cnt / TPB == frame_bits(parity_en) - 1) finish_frame();
        end
      end
      if (baud_tick) gtick++;
    end
  end

  task automatic push_byte(input logic [7:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    exp_q.push_back(d);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_drained();
    while (exp_q.size() != 0 || rx_busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic watch_line(input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      report();
    end
  end

  initial begin
    int lows;
    int base;
    void'($urandom(32'h0C75_1234));

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(txd == 1'b1, "R1 txd after reset", int'(txd), 1);
    check(wr_ready == 1'b1, "R1 wr_ready after reset", int'(wr_ready), 1);

    // R10: empty queue keeps the line idle
    watch_line(300, lows);
    check(lows == 0, "R10 idle while empty", lows, 0);

    // R2/R3: back-to-back corner bytes, no flow control, no parity
    tick_div = 2; flow_en = 0; parity_en = 0;
    have_prev = 0; gap_chk = 1;
    push_byte(8'h00); push_byte(8'hFF); push_byte(8'hA5); push_byte(8'h01);
    wait_drained();
    gap_chk = 0;
    check(rx_n == 4, "R2 frame count", rx_n, 4);
    watch_line(200, lows);
    check(lows == 0, "R10 idle after drain", lows, 0);

    // R9: flow control off, cts_n high is ignored
    cts_n = 1; flow_en = 0; have_prev = 0; gap_chk = 1;
    base = rx_n;
    push_byte(8'h3C); push_byte(8'hC3); push_byte(8'h80);
    wait_drained();
    gap_chk = 0;
    check(rx_n - base == 3, "R9 cts ignored", rx_n - base, 3);

    // R6: blocked before the first frame
    flow_en = 1; cts_n = 1;
    repeat (5) @(negedge clk);
    base = rx_n;
    push_byte(8'h5A); push_byte(8'h96);
    watch_line(800, lows);
    check(lows == 0, "R6 no start while blocked", lows, 0);
    check(rx_n == base, "R6 nothing sent", rx_n - base, 0);
    // R8: release
    cts_n = 0;
    wait_drained();
    check(rx_n - base == 2, "R8 resume after release", rx_n - base, 2);

    // R5: fill to 16, then a refused write
    cts_n = 1;
    repeat (5) @(negedge clk);
    base = rx_n;
    for (int i = 0; i < 16; i++) push_byte(8'(i * 17 + 3));
    check(wr_ready == 1'b0, "R5 ready low when full", int'(wr_ready), 0);
    wr_valid = 1'b1; wr_data = 8'hEE;
    @(negedge clk);
    wr_valid = 1'b0;
    check(wr_ready == 1'b0, "R5 ready stays low", int'(wr_ready), 0);
    cts_n = 0;
    wait_drained();
    watch_line(400, lows);
    check(rx_n - base == 16, "R5 sixteen bytes only", rx_n - base, 16);
    check(wr_ready == 1'b1, "R5 ready after drain", int'(wr_ready), 1);

    // R7: cts rises mid-frame; frame completes, then stall
    flow_en = 1; cts_n = 0;
    base = rx_n;
    push_byte(8'h11); push_byte(8'h22); push_byte(8'h33);
    while (!(rx_busy && rx_cnt >= 40)) @(negedge clk);
    cts_n = 1;
    while (rx_n == base) @(negedge clk);
    check(rx_n - base == 1, "R7 frame completes", rx_n - base, 1);
    watch_line(700, lows);
    check(lows == 0, "R7 line held high after frame", lows, 0);
    check(exp_q.size() == 2, "R7 remaining queued", exp_q.size(), 2);
    cts_n = 0;
    wait_drained();
    check(rx_n - base == 3, "R8 remaining bytes sent", rx_n - base, 3);

    // R4: parity even and odd, with R3 spacing at 11 bits
    flow_en = 0; parity_en = 1; parity_odd = 0; have_prev = 0; gap_chk = 1;
    push_byte(8'h00); push_byte(8'h07); push_byte(8'hFF);
    wait_drained();
    parity_odd = 1; have_prev = 0;
    push_byte(8'h00); push_byte(8'h07); push_byte(8'h81);
    wait_drained();
    gap_chk = 0;

    // random phases
    for (int ph = 0; ph < 4; ph++) begin
      parity_en  = 1'($urandom % 2);
      parity_odd = 1'($urandom % 2);
      tick_div   = 1 + int'($urandom % 3);
      flow_en    = 1'($urandom % 2);
      cts_n      = 1'b0;
      repeat (4) @(negedge clk);
      base = rx_n;
      for (int i = 0; i < 15; i++) begin
        push_byte(8'($urandom));
        repeat (int'($urandom % 20)) @(negedge clk);
      end
      wait_drained();
      check(rx_n - base == 15, "R2 random phase count", rx_n - base, 15);
    end

    done = 1;
    report();
  end
endmodule